// File: doc/BRIEF.md
# Power Resource Sequencer

The sequencer keeps a small group of power resources (regulators, power switches, clock sources) under control, turning each one on or off as the combined demand changes. Demand comes from three places: per-core clock requests, which a programmable table turns into resource masks; a standing minimum mask; and a set of countdown request timers, each of which asserts its own mask while it is running. The union of all three is the required set.

Every resource has its own four-state machine: OFF, RISING (turning on), ON and FALLING (turning off). It also has a timer that is loaded from that resource's programmed on-delay or off-delay. Delays are counted in low-power-oscillator ticks, and these ticks reach the block as a single-cycle enable `lpo_tick` in the main clock domain. A resource is not started until every resource named in its dependency mask is ON. A resource that is partway through a transition always finishes it before the opposite decision is taken. All tables are loaded through a simple write port.

The state transitions are: OFF to RISING (required, dependencies ON, on-delay nonzero), OFF to ON (same conditions, on-delay zero), RISING to ON (timer reaches zero on a tick), ON to FALLING (not required, off-delay nonzero), ON to OFF (not required, off-delay zero), and FALLING to OFF (timer reaches zero on a tick). A resource that meets none of these conditions stays in the state it is in.

Top module: `pwr_res_seq`

## Requirements
- R1: `res_state[2r+1:2r]` reports resource r with the encoding OFF=0, RISING=1, ON=2, FALLING=3. After reset every resource is OFF and `res_en` is all zero.
- R2: A resource's timer is zero while it is OFF or ON, and nonzero while it is RISING or FALLING.
- R3: When an OFF resource is required and its dependencies are met, it enters RISING with its timer set to its on-delay. The timer drops by one on each clock edge where `lpo_tick` is high, and the resource becomes ON at the edge where the timer reaches zero.
- R4: An on-delay of zero takes a resource from OFF directly to ON in one clock. An off-delay of zero takes it from ON directly to OFF in one clock.
- R5: When an ON resource is no longer required, it enters FALLING with its timer set to its off-delay, and it becomes OFF at the tick edge where the timer reaches zero.
- R6: The required set is the OR of the standing minimum mask, the clock-map entries of all asserted `clk_req` bits, and the masks of all running request timers.
- R7: Clock-map entry c gives the set of resources that `clk_req[c]` requires.
- R8: Writing a count to request timer t starts it. The timer counts down once per tick and asserts its mask while the count is nonzero.
- R9: A RISING resource finishes turning on even if it stops being required. A FALLING resource finishes turning off even if it becomes required again. The new decision is taken in the cycle after the state becomes stable.
- R10: A resource leaves OFF only when every resource in its dependency mask was ON in the cycle of the decision.
- R11: A write with `wr_en` high stores `wr_data` into the table chosen by `wr_addr = {kind[2:0], index}`. The kinds are 0 on-delay, 1 off-delay, 2 dependency mask, 3 clock map, 4 minimum mask (index ignored), 5 timer mask and 6 timer count. Every table resets to zero.
- R12: `res_en[r]` is high exactly while resource r is RISING or ON.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lpo_tick | input | 1 | One-cycle pulse per low-power-oscillator tick |
| clk_req | input | N_CLK | Per-core clock requests |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 3+IW | Table kind and index |
| wr_data | input | DW | Write data |
| res_en | output | N_RES | Per-resource enable |
| res_state | output | 2*N_RES | Per-resource state code |

## Verification
Some properties are checked by assertions on every cycle: a timer is zero exactly when its resource is in a stable state; a resource leaves OFF only when its dependencies were ready; a RISING resource can only move on to ON and a FALLING one only to OFF; and both the transition timers and the request timers count down by exactly one per tick. Other behaviour can only be shown by the bench scenarios, because it depends on the programmed tables: the exact tick on which a transition completes, the union of the three request sources, the mapping from clock requests to resources, and a re-request that is held back until a turn-off has finished.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        RS_OFF     = 2'd0,
        RS_RISING  = 2'd1,
        RS_ON      = 2'd2,
        RS_FALLING = 2'd3
    } rs_state_e;

    typedef enum logic [2:0] {
        K_ONTIME  = 3'd0,
        K_OFFTIME = 3'd1,
        K_DEP     = 3'd2,
        K_CLKMAP  = 3'd3,
        K_MIN     = 3'd4,
        K_TMASK   = 3'd5,
        K_TCOUNT  = 3'd6,
        K_NONE    = 3'd7
    } reg_kind_e;

endpackage

// File: rtl/pwr_seq_regs.sv
module pwr_seq_regs
    import pwr_seq_pkg::*;
#(
    parameter int N_RES = 4,
    parameter int N_CLK = 2,
    parameter int N_TMR = 2,
    parameter int TW    = 8,
    parameter int IW    = 2,
    parameter int DW    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [3+IW-1:0]                wr_addr,
    input  logic [DW-1:0]                  wr_data,
    output logic [N_RES-1:0][TW-1:0]       on_time,
    output logic [N_RES-1:0][TW-1:0]       off_time,
    output logic [N_RES-1:0][N_RES-1:0]    dep_mask,
    output logic [N_CLK-1:0][N_RES-1:0]    clk_map,
    output logic [N_RES-1:0]               min_mask,
    output logic [N_TMR-1:0][N_RES-1:0]    tmr_mask,
    output logic [N_TMR-1:0]               tmr_load,
    output logic [TW-1:0]                  tmr_load_val
);

    reg_kind_e      kind;
    logic [IW-1:0]  idx;

    assign kind         = reg_kind_e'(wr_addr[3+IW-1:IW]);
    assign idx          = wr_addr[IW-1:0];
    assign tmr_load_val = wr_data[TW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_time  <= '0;
            off_time <= '0;
            dep_mask <= '0;
            clk_map  <= '0;
            min_mask <= '0;
            tmr_mask <= '0;
        end else if (wr_en) begin
            for (int r = 0; r < N_RES; r++) begin
                if (idx == IW'(r)) begin
                    if (kind == K_ONTIME)  on_time[r]  <= wr_data[TW-1:0];
                    if (kind == K_OFFTIME) off_time[r] <= wr_data[TW-1:0];
                    if (kind == K_DEP)     dep_mask[r] <= wr_data[N_RES-1:0];
                end
            end
            for (int c = 0; c < N_CLK; c++) begin
                if (kind == K_CLKMAP && idx == IW'(c)) clk_map[c] <= wr_data[N_RES-1:0];
            end
            for (int t = 0; t < N_TMR; t++) begin
                if (kind == K_TMASK && idx == IW'(t)) tmr_mask[t] <= wr_data[N_RES-1:0];
            end
            if (kind == K_MIN) min_mask <= wr_data[N_RES-1:0];
        end
    end

    always_comb begin
        for (int t = 0; t < N_TMR; t++) begin
            tmr_load[t] = wr_en && kind == K_TCOUNT && idx == IW'(t);
        end
    end

    assert_load_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_load));

endmodule

// File: rtl/pwr_seq_reqtimer.sv
module pwr_seq_reqtimer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          active
);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= load_val;
        else if (tick && cnt != 0)  cnt <= cnt - 1'b1;
    end

    assign active = (cnt != '0);

    assert_tmr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick && !load) |=> (cnt == $past(cnt) - 1'b1));

    assert_tmr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt));

endmodule

// File: rtl/pwr_seq_res.sv
module pwr_seq_res
    import pwr_seq_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          needed,
    input  logic          deps_ready,
    input  logic [TW-1:0] on_time,
    input  logic [TW-1:0] off_time,
    output rs_state_e     state,
    output logic          en
);

    rs_state_e     state_nx;
    logic [TW-1:0] tmr, tmr_nx;

    always_comb begin
        state_nx = state;
        tmr_nx   = tmr;
        unique case (state)
            RS_OFF: begin
                if (needed && deps_ready) begin
                    if (on_time == '0) state_nx = RS_ON;
                    else begin
                        state_nx = RS_RISING;
                        tmr_nx   = on_time;
                    end
                end
            end
            RS_RISING: begin
                if (tick) begin
                    tmr_nx = tmr - 1'b1;
                    if (tmr == TW'(1)) state_nx = RS_ON;
                end
            end
            RS_ON: begin
                if (!needed) begin
                    if (off_time == '0) state_nx = RS_OFF;
                    else begin
                        state_nx = RS_FALLING;
                        tmr_nx   = off_time;
                    end
                end
            end
            RS_FALLING: begin
                if (tick) begin
                    tmr_nx = tmr - 1'b1;
                    if (tmr == TW'(1)) state_nx = RS_OFF;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RS_OFF;
            tmr   <= '0;
        end else begin
            state <= state_nx;
            tmr   <= tmr_nx;
        end
    end

    always_comb begin
        en = (state == RS_RISING) || (state == RS_ON);
    end

    assert_stable_tmr_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_OFF || state == RS_ON) |-> (tmr == '0));

    assert_transit_tmr_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_RISING || state == RS_FALLING) |-> (tmr != '0));

    assert_deps_before_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_OFF && state_nx != RS_OFF) |-> deps_ready);

    assert_rise_completes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_RISING) |=> (state == RS_RISING || state == RS_ON));

    assert_fall_completes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_FALLING) |=> (state == RS_FALLING || state == RS_OFF));

    assert_tick_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_RISING && tick) |=> (tmr == $past(tmr) - 1'b1));

endmodule

// File: rtl/pwr_res_seq.sv
module pwr_res_seq
    import pwr_seq_pkg::*;
#(
    parameter int N_RES = 4,
    parameter int N_CLK = 2,
    parameter int N_TMR = 2,
    parameter int TW    = 8,
    localparam int MAXN = (N_RES > N_CLK) ? ((N_RES > N_TMR) ? N_RES : N_TMR)
                                          : ((N_CLK > N_TMR) ? N_CLK : N_TMR),
    localparam int IW   = (MAXN > 1) ? $clog2(MAXN) : 1,
    localparam int AW   = 3 + IW,
    localparam int DW   = (TW > N_RES) ? TW : N_RES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lpo_tick,
    input  logic [N_CLK-1:0]   clk_req,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    output logic [N_RES-1:0]   res_en,
    output logic [2*N_RES-1:0] res_state
);

    logic [N_RES-1:0][TW-1:0]    on_time, off_time;
    logic [N_RES-1:0][N_RES-1:0] dep_mask;
    logic [N_CLK-1:0][N_RES-1:0] clk_map;
    logic [N_RES-1:0]            min_mask;
    logic [N_TMR-1:0][N_RES-1:0] tmr_mask;
    logic [N_TMR-1:0]            tmr_load, tmr_active;
    logic [TW-1:0]               tmr_load_val;
    logic [N_RES-1:0]            required, is_on;

    pwr_seq_regs #(
        .N_RES(N_RES), .N_CLK(N_CLK), .N_TMR(N_TMR), .TW(TW), .IW(IW), .DW(DW)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .on_time(on_time), .off_time(off_time), .dep_mask(dep_mask), .clk_map(clk_map),
        .min_mask(min_mask), .tmr_mask(tmr_mask), .tmr_load(tmr_load),
        .tmr_load_val(tmr_load_val)
    );

    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
        pwr_seq_reqtimer #(.TW(TW)) tmr_i (
            .clk(clk), .rst_n(rst_n), .tick(lpo_tick), .load(tmr_load[t]),
            .load_val(tmr_load_val), .active(tmr_active[t])
        );
    end

    always_comb begin
        required = min_mask;
        for (int c = 0; c < N_CLK; c++) begin
            if (clk_req[c]) required = required | clk_map[c];
        end
        for (int t = 0; t < N_TMR; t++) begin
            if (tmr_active[t]) required = required | tmr_mask[t];
        end
    end

    for (genvar r = 0; r < N_RES; r++) begin : g_res
        rs_state_e st;
        logic      deps_ok;

        assign deps_ok = ((dep_mask[r] & is_on) == dep_mask[r]);

        pwr_seq_res #(.TW(TW)) res_i (
            .clk(clk), .rst_n(rst_n), .tick(lpo_tick), .needed(required[r]),
            .deps_ready(deps_ok), .on_time(on_time[r]), .off_time(off_time[r]),
            .state(st), .en(res_en[r])
        );

        assign is_on[r]         = (st == RS_ON);
        assign res_state[2*r+:2] = st;

        assert_en_matches_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
            res_en[r] == (st == RS_RISING || st == RS_ON));
    end

endmodule

// File: tb/pwr_res_seq_tb.sv
`timescale 1ns/1ps
module pwr_res_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lpo_tick = 1'b0;
    logic [1:0] clk_req = '0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] res_en;
    logic [7:0] res_state;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pwr_res_seq dut_i (
        .clk(clk), .rst_n(rst_n), .lpo_tick(lpo_tick), .clk_req(clk_req),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .res_en(res_en), .res_state(res_state)
    );

    // {clk_req[1:0], tick, expected res_state[7:0]}
    localparam logic [10:0] VEC [18] = '{
        {2'b01, 1'b0, 8'h09},  // R3 r0 rising, R4 r1 straight on, R7 map c0
        {2'b11, 1'b1, 8'h09},  // R10 r2 waits for r0
        {2'b11, 1'b1, 8'h0A},  // R3 r0 on at zero
        {2'b11, 1'b0, 8'h1A},  // R10 r2 starts once r0 on
        {2'b01, 1'b1, 8'h1A},  // R9 rising continues
        {2'b01, 1'b1, 8'h1A},
        {2'b01, 1'b1, 8'h2A},  // R9 finish on first
        {2'b01, 1'b0, 8'h3A},  // R5 falling
        {2'b11, 1'b1, 8'h3A},  // R9 falling despite request
        {2'b11, 1'b1, 8'h0A},  // R5 off at zero
        {2'b11, 1'b0, 8'h1A},  // R9 re-decision after stable
        {2'b00, 1'b0, 8'h13},  // R5 r0 falling, R4 r1 off immediately
        {2'b00, 1'b1, 8'h10},
        {2'b00, 1'b1, 8'h10},
        {2'b00, 1'b1, 8'h20},
        {2'b00, 1'b0, 8'h30},
        {2'b00, 1'b1, 8'h30},
        {2'b00, 1'b1, 8'h00}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] kind, input logic [1:0] idx, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = {kind, idx}; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(); step();
        check("R1 reset state", res_state, 8'h00);
        check("R1 reset enable", {4'h0, res_en}, 8'h00);
        rst_n = 1'b1;
        step();
        // R11 table programming
        wr(3'd0, 2'd0, 8'd2); wr(3'd0, 2'd1, 8'd0); wr(3'd0, 2'd2, 8'd3); wr(3'd0, 2'd3, 8'd1);
        wr(3'd1, 2'd0, 8'd1); wr(3'd1, 2'd1, 8'd0); wr(3'd1, 2'd2, 8'd2); wr(3'd1, 2'd3, 8'd0);
        wr(3'd2, 2'd2, 8'h01);
        wr(3'd3, 2'd0, 8'h03); wr(3'd3, 2'd1, 8'h04);
        check("R11 tables do not start anything", res_state, 8'h00);

        for (int i = 0; i < 18; i++) begin
            clk_req  = VEC[i][10:9];
            lpo_tick = VEC[i][8];
            step();
            check($sformatf("R3/R5/R9 vector %0d", i), res_state, VEC[i][7:0]);
        end
        lpo_tick = 1'b0;
        check("R12 enables after sequence", {4'h0, res_en}, 8'h00);

        // R6 minimum mask
        wr(3'd4, 2'd0, 8'h08);
        step();
        check("R6 min mask starts r3", res_state, 8'h40);
        check("R12 enable while rising", {4'h0, res_en}, 8'h08);
        lpo_tick = 1'b1; step(); lpo_tick = 1'b0;
        check("R3 r3 on after one tick", res_state, 8'h80);
        wr(3'd4, 2'd0, 8'h00);
        step();
        check("R4 zero off-delay r3 off", res_state, 8'h00);

        // R8 request timer
        wr(3'd5, 2'd0, 8'h02);
        wr(3'd6, 2'd0, 8'd2);
        step();
        check("R8 timer request turns r1 on", res_state, 8'h08);
        lpo_tick = 1'b1; step();
        check("R8 timer still running", res_state, 8'h08);
        step(); lpo_tick = 1'b0;
        check("R8 r1 held in expiry cycle", res_state, 8'h08);
        step();
        check("R8 r1 off after expiry", res_state, 8'h00);

        // R1 reset mid-operation
        clk_req = 2'b01;
        step(); step();
        check("R4 r1 on again", res_state[3:2], 8'h02);
        rst_n = 1'b0;
        #1;
        check("R1 async reset", res_state, 8'h00);
        clk_req = 2'b00;
        step();
        rst_n = 1'b1;
        step();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule